// File: doc/BRIEF.md
# Configuration Command Handshake Unit

This block holds a three-word register window through which software issues configuration commands to the board. Software first places an argument in the data word, then writes a command word to the control register. On that write the unit drops two reserved bits from the command, stores the result and classifies it. It answers in the same clock edge by updating a two-bit status word. One recognised command raises a single-cycle shutdown request and another raises a single-cycle reboot request. Any other command marks the status with an error. Software may later overwrite the status word to clear it.

The window exists only on a board variant that supports it. A strap input selects that variant. When the strap is low, every access to the three offsets reads as zero and changes nothing, and the unit flags the access as bad on a combinational output. Reads are combinational and writes take effect at the rising clock edge.

Top module: `cfgcmd_unit`

## Requirements
- R1: With `variant_en_i` high, the data word at byte offset 0xA0 is a plain 32-bit read/write register. A read returns the value last written to it.
- R2: A control write at offset 0xA4 stores the written word with bits 19 and 18 forced to zero. Later reads of 0xA4 return that masked value.
- R3: Every accepted control write sets status bit 0 (done), which is visible at offset 0xA8 from the next cycle.
- R4: A masked command of 0xC0800000 produces exactly one cycle of `shutdown_o`, and a masked command of 0xC0900000 produces exactly one cycle of `reboot_o`. Both pulses appear in the cycle after the write, and the two never occur together.
- R5: After any other masked command, status reads 2'b11 (done and error) and neither request pulses. After a recognised command, status reads 2'b01.
- R6: A write to status at 0xA8 stores only bits 1:0 of the written word, and status bits 31:2 always read zero.
- R7: With `variant_en_i` low, the following hold for offsets 0xA0, 0xA4 and 0xA8. Reads return zero. Writes change no register and raise no request. `bad_access_o` is high in the cycle of the access.
- R8: An asynchronous reset (`rst_ni` low) clears all three registers to zero and holds both request outputs low.
- R9: Reads of offsets other than the three return zero and never raise `bad_access_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| variant_en_i | input | 1 | Strap: high on the board variant that has the window |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| bad_access_o | output | 1 | Access to the window on a variant without it |
| shutdown_o | output | 1 | One-cycle shutdown request |
| reboot_o | output | 1 | One-cycle reboot request |

## Verification
The bench aims at the command decode when bits 19:18 of the written word are set. The shutdown and reboot codes with those bits set must still be recognised. A design that compared the word before masking would report an error there instead of pulsing. The bench also writes status right after a command, to confirm that only two bits survive. It checks that a request lasts one cycle, so a level-held request is caught. Finally it turns the strap off while registers hold data, then writes and reads. A design that leaked state or accepted writes in that mode would show non-zero reads or changed values once the strap returns.

// File: rtl/cfgcmd_pkg.sv
package cfgcmd_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NREG   = 3;
  localparam int unsigned STAT_W = 2;

  localparam int unsigned IDX_DATA = 0;
  localparam int unsigned IDX_CTRL = 1;
  localparam int unsigned IDX_STAT = 2;

  localparam logic [WORD_W-1:0] CTRL_KEEP     = 32'hFFF3_FFFF;
  localparam logic [WORD_W-1:0] CODE_SHUTDOWN = 32'hC080_0000;
  localparam logic [WORD_W-1:0] CODE_REBOOT   = 32'hC090_0000;

  localparam logic [STAT_W-1:0] STAT_OK  = 2'b01;
  localparam logic [STAT_W-1:0] STAT_ERR = 2'b11;

  typedef enum logic [1:0] {
    CMD_OTHER    = 2'd0,
    CMD_SHUTDOWN = 2'd1,
    CMD_REBOOT   = 2'd2
  } cmd_kind_e;

  function automatic logic [11:0] reg_offset(int unsigned idx);
    case (idx)
      IDX_DATA: reg_offset = 12'h0A0;
      IDX_CTRL: reg_offset = 12'h0A4;
      default:  reg_offset = 12'h0A8;
    endcase
  endfunction
endpackage

// File: rtl/cfgcmd_decode.sv
module cfgcmd_decode
  import cfgcmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   sel_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign sel_o[g] = (addr_i == ADDR_W'(reg_offset(g)));
  end
endmodule

// File: rtl/cfgcmd_classify.sv
module cfgcmd_classify
  import cfgcmd_pkg::*;
(
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] masked_o,
  output cmd_kind_e         kind_o
);
  always_comb begin
    masked_o = wdata_i & CTRL_KEEP;
    if (masked_o == CODE_SHUTDOWN)    kind_o = CMD_SHUTDOWN;
    else if (masked_o == CODE_REBOOT) kind_o = CMD_REBOOT;
    else                              kind_o = CMD_OTHER;
  end
endmodule

// File: rtl/cfgcmd_regs.sv
module cfgcmd_regs
  import cfgcmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_data_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_stat_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] masked_i,
  input  cmd_kind_e         kind_i,
  output logic [WORD_W-1:0] data_q_o,
  output logic [WORD_W-1:0] ctrl_q_o,
  output logic [STAT_W-1:0] stat_q_o,
  output logic              shutdown_o,
  output logic              reboot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o   <= '0;
      ctrl_q_o   <= '0;
      stat_q_o   <= '0;
      shutdown_o <= 1'b0;
      reboot_o   <= 1'b0;
    end else begin
      if (wr_data_i) data_q_o <= wdata_i;
      if (wr_ctrl_i) begin
        ctrl_q_o <= masked_i;
        stat_q_o <= (kind_i == CMD_OTHER) ? STAT_ERR : STAT_OK;
      end else if (wr_stat_i) begin
        stat_q_o <= wdata_i[STAT_W-1:0];
      end
      shutdown_o <= wr_ctrl_i && (kind_i == CMD_SHUTDOWN);
      reboot_o   <= wr_ctrl_i && (kind_i == CMD_REBOOT);
    end
  end

  assert_ctrl_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl_i |=> (ctrl_q_o[19:18] == 2'b00));
  assert_done_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl_i |=> stat_q_o[0]);
  assert_req_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shutdown_o && reboot_o));
  assert_req_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_o || reboot_o) |=> !(shutdown_o || reboot_o) || $past(wr_ctrl_i));
  assert_req_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl_i && (kind_i != CMD_OTHER) |=> (shutdown_o || reboot_o) && (stat_q_o == STAT_OK));
  assert_err_status_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl_i && (kind_i == CMD_OTHER) |=> (stat_q_o == STAT_ERR) && !shutdown_o && !reboot_o);
endmodule

// File: rtl/cfgcmd_unit.sv
module cfgcmd_unit
  import cfgcmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              variant_en_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              bad_access_o,
  output logic              shutdown_o,
  output logic              reboot_o
);
  logic [NREG-1:0]   sel;
  logic [WORD_W-1:0] masked;
  cmd_kind_e         kind;
  logic [WORD_W-1:0] data_q, ctrl_q;
  logic [STAT_W-1:0] stat_q;
  logic              wr_ok;

  cfgcmd_decode #(.ADDR_W(ADDR_W)) u_decode (.addr_i(addr_i), .sel_o(sel));

  cfgcmd_classify u_classify (.wdata_i(wdata_i), .masked_o(masked), .kind_o(kind));

  assign wr_ok = wr_en_i && variant_en_i;

  cfgcmd_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_data_i (wr_ok && sel[IDX_DATA]),
    .wr_ctrl_i (wr_ok && sel[IDX_CTRL]),
    .wr_stat_i (wr_ok && sel[IDX_STAT]),
    .wdata_i   (wdata_i),
    .masked_i  (masked),
    .kind_i    (kind),
    .data_q_o  (data_q),
    .ctrl_q_o  (ctrl_q),
    .stat_q_o  (stat_q),
    .shutdown_o(shutdown_o),
    .reboot_o  (reboot_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i && variant_en_i) begin
      if (sel[IDX_DATA])      rdata_o = data_q;
      else if (sel[IDX_CTRL]) rdata_o = ctrl_q;
      else if (sel[IDX_STAT]) rdata_o = {{(WORD_W-STAT_W){1'b0}}, stat_q};
    end
  end

  assign bad_access_o = (wr_en_i || rd_en_i) && (|sel) && !variant_en_i;

  assert_absent_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !variant_en_i) |=> $stable(data_q) && $stable(ctrl_q) && $stable(stat_q)
                                   && !shutdown_o && !reboot_o);
  assert_absent_reads_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !variant_en_i) |-> (rdata_o == '0));
  assert_no_bad_outside_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_access_o |-> (addr_i == ADDR_W'(reg_offset(IDX_DATA))) ||
                     (addr_i == ADDR_W'(reg_offset(IDX_CTRL))) ||
                     (addr_i == ADDR_W'(reg_offset(IDX_STAT))));
  assert_data_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && variant_en_i && (addr_i == ADDR_W'(reg_offset(IDX_DATA)))) |=>
      (data_q == $past(wdata_i)));
endmodule

// File: tb/sim_cfgcmd_unit.sv
module sim_cfgcmd_unit;
  localparam int unsigned AW = 12;
  localparam logic [AW-1:0] A_DATA = 12'h0A0, A_CTRL = 12'h0A4, A_STAT = 12'h0A8;

  logic clk = 1'b0, rst_n = 1'b0, ven = 1'b1, wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic bad, sd, rb;

  int n_chk = 0, n_err = 0;
  logic [31:0] m_data = 0, m_ctrl = 0;
  logic [1:0]  m_stat = 0;

  always #2 clk = ~clk;

  cfgcmd_unit #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .variant_en_i(ven), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .bad_access_o(bad),
    .shutdown_o(sd), .reboot_o(rb));

  function automatic logic [31:0] f_mask(logic [31:0] v);
    return v & ~(32'h3 << 18);
  endfunction
  function automatic logic [1:0] f_kind(logic [31:0] v); // 1 shutdown, 2 reboot, 0 other
    if (f_mask(v) == 32'hC080_0000) return 2'd1;
    if (f_mask(v) == 32'hC090_0000) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [31:0] d);
    logic [1:0] k;
    logic hit;
    hit = (a == A_DATA) || (a == A_CTRL) || (a == A_STAT);
    k = f_kind(d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    #1 check("R7 bad on write", {31'b0, bad}, {31'b0, hit && !ven});
    @(negedge clk);
    wr = 1'b0;
    if (ven && a == A_CTRL) begin
      m_ctrl = f_mask(d);
      m_stat = (k == 0) ? 2'b11 : 2'b01;
      check("R4 shutdown pulse", {31'b0, sd}, {31'b0, k == 2'd1});
      check("R4 reboot pulse", {31'b0, rb}, {31'b0, k == 2'd2});
    end else begin
      if (ven && a == A_DATA) m_data = d;
      if (ven && a == A_STAT) m_stat = d[1:0];
      check("R7 no request", {30'b0, sd, rb}, 32'd0);
    end
    @(negedge clk);
    check("R4 single cycle", {30'b0, sd, rb}, 32'd0);
  endtask

  task automatic do_read(logic [AW-1:0] a, string req);
    logic [31:0] exp;
    logic hit;
    hit = (a == A_DATA) || (a == A_CTRL) || (a == A_STAT);
    exp = 0;
    if (ven) begin
      if (a == A_DATA) exp = m_data;
      else if (a == A_CTRL) exp = m_ctrl;
      else if (a == A_STAT) exp = {30'b0, m_stat};
    end
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 check(req, rdata, exp);
    check("R7 R9 bad on read", {31'b0, bad}, {31'b0, hit && !ven});
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R8 reset requests", {30'b0, sd, rb}, 32'd0);
    rst_n = 1'b1;
    do_read(A_DATA, "R8 data reset");
    do_read(A_CTRL, "R8 ctrl reset");
    do_read(A_STAT, "R8 stat reset");

    do_write(A_DATA, 32'hDEAD_BEEF);  do_read(A_DATA, "R1 data rw");
    do_write(A_CTRL, 32'hFFFF_FFFF);  do_read(A_CTRL, "R2 ctrl mask");
    do_read(A_STAT, "R5 error status");
    do_write(A_STAT, 32'hFFFF_FFFC);  do_read(A_STAT, "R6 stat clear");
    do_write(A_CTRL, 32'hC080_0000);  do_read(A_STAT, "R3 R5 ok status");
    do_write(A_STAT, 32'h0000_0006);  do_read(A_STAT, "R6 two bits only");
    do_write(A_CTRL, 32'hC09C_0000);  do_read(A_CTRL, "R2 R4 reboot masked");
    do_write(A_CTRL, 32'hC08C_0000);  do_read(A_STAT, "R4 shutdown masked");
    do_write(A_CTRL, 32'hC0A0_0000);  do_read(A_STAT, "R5 near code");
    do_read(12'h0AC, "R9 outside read");
    do_read(12'h000, "R9 outside read");

    ven = 1'b0;
    do_read(A_DATA, "R7 absent data read");
    do_write(A_DATA, 32'h1234_5678);
    do_write(A_CTRL, 32'hC090_0000);
    do_write(A_STAT, 32'h0);
    ven = 1'b1;
    do_read(A_DATA, "R7 data kept");
    do_read(A_CTRL, "R7 ctrl kept");
    do_read(A_STAT, "R7 stat kept");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r, d;
      logic [AW-1:0] a;
      r = $urandom;
      case (r[1:0])
        2'd0: a = A_DATA;
        2'd1: a = A_CTRL;
        2'd2: a = A_STAT;
        default: a = AW'($urandom_range(0, 255));
      endcase
      case (r[4:2])
        3'd0: d = 32'hC080_0000 | ({30'b0, r[6:5]} << 18);
        3'd1: d = 32'hC090_0000 | ({30'b0, r[6:5]} << 18);
        default: d = $urandom;
      endcase
      ven = (r[10:8] != 3'd0);
      if (r[7]) do_write(a, d);
      else      do_read(a, "R1 R2 R6 random read");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule